// File: doc/BRIEF.md
# Evenly Spaced Step-Pulse Burst Generator

This block drives a stepper motor's step input. Time is cut into frames of a fixed length: `FRAME_TICKS` ticks, each tick being `TICK_DIV` system clocks. With the defaults of 50 and 1000 and a 50 MHz clock, that is 1 MHz ticks and 1 ms frames. Each frame opens with an active window of W ticks, about 900 by default. Within that window the block emits exactly N step pulses spread evenly across it, where N is between 0 and 255. The rest of the frame is an idle tail.

The spacing comes from a 16-bit phase accumulator. At the start of each frame the accumulator is cleared. On every tick inside the window, a per-frame increment I = ceil(N * 2^16 / W) is added to it. Each carry out of the top bit produces one pulse. Guard logic counts the pulses already sent. It blocks any carry beyond N and forces a pulse if the remaining count would no longer fit in the remaining slots. The burst length is therefore exact whatever the arithmetic does.

When the window closes, the block raises a ready flag toward the host. The host hands over the next count and window length with a valid/ready transfer during the idle tail. The new values take effect at the next frame boundary. If the host sends nothing, the previous values are used again.

Top module: `step_burst_gen`

## Requirements
- R1: After synchronous active-high reset, `step_out` is 0, `cfg_ready` is 1, the frame position is 0, and the first frame emits no pulses (its active count is 0).
- R2: A frame is always `FRAME_TICKS` ticks long, and a tick occurs every `TICK_DIV` clocks, the first one `TICK_DIV` clocks after reset. Count and window values take effect only at the tick that ends the last slot of a frame.
- R3: A frame whose active count is N emits exactly N pulses. A count of 0 emits none.
- R4: With I = ceil(N*2^16/W) and an accumulator cleared at frame start, slot p (0-based, p < W) emits a pulse when adding I to the 16-bit accumulator carries out, up to N pulses in total. `step_out` rises one clock after that slot's tick and stays high for exactly one tick period.
- R5: An accepted window length is clamped to the range [2^CNT_W - 1, FRAME_TICKS - 2]. The reset window is `DEF_WIN`, clamped the same way.
- R6: `cfg_ready` rises one clock after the tick that ends slot W-1 of the active window. It falls after an accepted transfer, or after the tick that ends slot FRAME_TICKS-2, whichever comes first. It is therefore 0 throughout the last slot. If the transfer and the window end fall on the same clock, the transfer wins.
- R7: Data is captured only on a clock where `cfg_valid` and `cfg_ready` are both 1. A `cfg_valid` pulse while `cfg_ready` is 0 changes nothing.
- R8: If no transfer happens during a frame, the next frame uses the same count and window again.
- R9: `step_out` is high only while the frame position is between 1 and W inclusive, so no pulse ever appears in the idle tail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Host offers a new count and window |
| cfg_count | input | CNT_W | Pulse count for the next frame |
| cfg_window | input | WIN_W | Active window length in ticks for the next frame |
| cfg_ready | output | 1 | Block is requesting data for the next frame |
| step_out | output | 1 | Registered step pulse, one tick wide |

## Verification
On every cycle the assertions check the following:
- `step_out` changes only right after a tick.
- The number of tick-sampled pulses at each frame boundary equals the count that was active for that frame.
- No pulse appears outside positions 1 to W.
- `cfg_ready` is low in the last slot and rises only after a tick.

The bench scenarios show the rest:
- The exact slot of every pulse for several counts and windows.
- A full 255-in-255 burst.
- Clamping at both ends.
- A valid that is ignored while ready is low.
- A frame that reuses the old data.

// File: rtl/sbg_pkg.sv
package sbg_pkg;

    // Where the current frame position sits relative to the active window.
    typedef enum logic [1:0] {
        SLOT_WINDOW = 2'd0,
        SLOT_TAIL   = 2'd1,
        SLOT_LAST   = 2'd2
    } slot_kind_e;

endpackage

// File: rtl/sbg_tick_div.sv
module sbg_tick_div #(
    parameter int TICK_DIV = 50
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        tick  = (div_q == DIV_LAST);
        div_d = tick ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_d;
    end
endmodule

// File: rtl/sbg_frame_timer.sv
module sbg_frame_timer
    import sbg_pkg::*;
#(
    parameter int FRAME_TICKS = 1000,
    parameter int WIN_W       = $clog2(FRAME_TICKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [WIN_W-1:0] act_win,
    output logic [WIN_W-1:0] pos,
    output slot_kind_e       kind,
    output logic             win_end,
    output logic             close_req,
    output logic             load
);
    localparam logic [WIN_W-1:0] POS_LAST  = WIN_W'(FRAME_TICKS - 1);
    localparam logic [WIN_W-1:0] POS_CLOSE = WIN_W'(FRAME_TICKS - 2);

    logic [WIN_W-1:0] pos_d, pos_q;

    always_comb begin
        if (pos_q < act_win)        kind = SLOT_WINDOW;
        else if (pos_q == POS_LAST) kind = SLOT_LAST;
        else                        kind = SLOT_TAIL;

        win_end   = tick && (pos_q == act_win - 1'b1);
        close_req = tick && (pos_q == POS_CLOSE);
        load      = tick && (kind == SLOT_LAST);

        pos_d = pos_q;
        if (load)      pos_d = '0;
        else if (tick) pos_d = pos_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) pos_q <= '0;
        else     pos_q <= pos_d;
    end

    assign pos = pos_q;
endmodule

// File: rtl/sbg_host_latch.sv
module sbg_host_latch #(
    parameter int CNT_W       = 8,
    parameter int ACC_W       = 16,
    parameter int FRAME_TICKS = 1000,
    parameter int WIN_W       = $clog2(FRAME_TICKS),
    parameter int DEF_WIN     = 900
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_valid,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [WIN_W-1:0] cfg_window,
    input  logic             win_end,
    input  logic             close_req,
    input  logic             load,
    output logic             cfg_ready,
    output logic [CNT_W-1:0] act_cnt,
    output logic [WIN_W-1:0] act_win,
    output logic [ACC_W:0]   act_inc
);
    localparam int INC_W = ACC_W + 1;
    localparam int NUM_W = CNT_W + ACC_W + 1;
    localparam logic [WIN_W-1:0] MIN_WIN = WIN_W'((2 ** CNT_W) - 1);
    localparam logic [WIN_W-1:0] MAX_WIN = WIN_W'(FRAME_TICKS - 2);

    function automatic logic [WIN_W-1:0] clamp_win(input logic [WIN_W-1:0] w);
        if (w < MIN_WIN) return MIN_WIN;
        if (w > MAX_WIN) return MAX_WIN;
        return w;
    endfunction

    localparam logic [WIN_W-1:0] DEF_CLAMPED = clamp_win(WIN_W'(DEF_WIN));

    typedef struct packed {
        logic [CNT_W-1:0] pend_cnt;
        logic [WIN_W-1:0] pend_win;
        logic [CNT_W-1:0] act_cnt;
        logic [WIN_W-1:0] act_win;
        logic [INC_W-1:0] act_inc;
        logic             req;
    } latch_s;

    latch_s           st_d, st_q;
    logic             accept;
    logic [NUM_W-1:0] num;
    logic [INC_W-1:0] pend_inc;

    always_comb begin
        // Ceiling of count * 2^ACC_W / window, taken from the pending values.
        num = NUM_W'({st_q.pend_cnt, {ACC_W{1'b0}}}) + NUM_W'(st_q.pend_win) - NUM_W'(1);
        pend_inc = INC_W'(num / NUM_W'(st_q.pend_win));

        accept = cfg_valid && st_q.req;
        st_d   = st_q;

        if (load) begin
            st_d.act_cnt = st_q.pend_cnt;
            st_d.act_win = st_q.pend_win;
            st_d.act_inc = pend_inc;
        end

        if (win_end)   st_d.req = 1'b1;
        if (close_req) st_d.req = 1'b0;

        if (accept) begin
            st_d.pend_cnt = cfg_count;
            st_d.pend_win = clamp_win(cfg_window);
            st_d.req      = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pend_cnt <= '0;
            st_q.pend_win <= DEF_CLAMPED;
            st_q.act_cnt  <= '0;
            st_q.act_win  <= DEF_CLAMPED;
            st_q.act_inc  <= '0;
            st_q.req      <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_ready = st_q.req;
    assign act_cnt   = st_q.act_cnt;
    assign act_win   = st_q.act_win;
    assign act_inc   = st_q.act_inc;
endmodule

// File: rtl/sbg_phase_accum.sv
module sbg_phase_accum
    import sbg_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int ACC_W = 16,
    parameter int WIN_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  slot_kind_e       kind,
    input  logic [WIN_W-1:0] pos,
    input  logic             load,
    input  logic [CNT_W-1:0] act_cnt,
    input  logic [WIN_W-1:0] act_win,
    input  logic [ACC_W:0]   act_inc,
    output logic             step
);
    localparam int CMP_W = ((CNT_W > WIN_W) ? CNT_W : WIN_W) + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] sent;
        logic             step;
    } accum_s;

    accum_s           st_d, st_q;
    logic [ACC_W:0]   sum;
    logic             carry;
    logic [CNT_W-1:0] remaining;
    logic [WIN_W-1:0] slots_left;
    logic             force_now;
    logic             emit;

    always_comb begin
        sum        = {1'b0, st_q.acc} + act_inc;
        carry      = sum[ACC_W];
        remaining  = act_cnt - st_q.sent;
        slots_left = act_win - pos;
        // Must fire now if every remaining slot is needed for the remaining pulses.
        force_now  = CMP_W'(remaining) >= CMP_W'(slots_left);
        emit       = (remaining != '0) && (carry || force_now);

        st_d = st_q;
        if (load) begin
            st_d.acc  = '0;
            st_d.sent = '0;
            st_d.step = 1'b0;
        end else if (tick) begin
            if (kind == SLOT_WINDOW) begin
                st_d.acc  = sum[ACC_W-1:0];
                st_d.step = emit;
                if (emit) st_d.sent = st_q.sent + 1'b1;
            end else begin
                st_d.step = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.acc  <= '0;
            st_q.sent <= '0;
            st_q.step <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign step = st_q.step;
endmodule

// File: rtl/step_burst_gen.sv
module step_burst_gen
    import sbg_pkg::*;
#(
    parameter int TICK_DIV    = 50,
    parameter int FRAME_TICKS = 1000,
    parameter int DEF_WIN     = 900,
    parameter int CNT_W       = 8,
    parameter int ACC_W       = 16,
    parameter int WIN_W       = $clog2(FRAME_TICKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_valid,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [WIN_W-1:0] cfg_window,
    output logic             cfg_ready,
    output logic             step_out
);
    logic             tick;
    logic [WIN_W-1:0] pos;
    slot_kind_e       kind;
    logic             win_end;
    logic             close_req;
    logic             load;
    logic [CNT_W-1:0] act_cnt;
    logic [WIN_W-1:0] act_win;
    logic [ACC_W:0]   act_inc;

    sbg_tick_div #(.TICK_DIV(TICK_DIV)) u_tick_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    sbg_frame_timer #(.FRAME_TICKS(FRAME_TICKS), .WIN_W(WIN_W)) u_frame_timer (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .act_win   (act_win),
        .pos       (pos),
        .kind      (kind),
        .win_end   (win_end),
        .close_req (close_req),
        .load      (load)
    );

    sbg_host_latch #(
        .CNT_W(CNT_W), .ACC_W(ACC_W), .FRAME_TICKS(FRAME_TICKS),
        .WIN_W(WIN_W), .DEF_WIN(DEF_WIN)
    ) u_host_latch (
        .clk        (clk),
        .rst        (rst),
        .cfg_valid  (cfg_valid),
        .cfg_count  (cfg_count),
        .cfg_window (cfg_window),
        .win_end    (win_end),
        .close_req  (close_req),
        .load       (load),
        .cfg_ready  (cfg_ready),
        .act_cnt    (act_cnt),
        .act_win    (act_win),
        .act_inc    (act_inc)
    );

    sbg_phase_accum #(.CNT_W(CNT_W), .ACC_W(ACC_W), .WIN_W(WIN_W)) u_phase_accum (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .kind    (kind),
        .pos     (pos),
        .load    (load),
        .act_cnt (act_cnt),
        .act_win (act_win),
        .act_inc (act_inc),
        .step    (step_out)
    );
endmodule

// File: rtl/sbg_checker.sv
module sbg_checker #(
    parameter int CNT_W       = 8,
    parameter int WIN_W       = 10,
    parameter int FRAME_TICKS = 1000
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             load,
    input logic [WIN_W-1:0] pos,
    input logic [CNT_W-1:0] act_cnt,
    input logic [WIN_W-1:0] act_win,
    input logic             cfg_ready,
    input logic             step_out
);
    localparam logic [WIN_W-1:0] POS_LAST = WIN_W'(FRAME_TICKS - 1);

    logic [CNT_W:0] pulse_cnt;

    // Pulses seen in the current frame, sampled once per tick.
    always_ff @(posedge clk) begin
        if (rst || load)           pulse_cnt <= '0;
        else if (tick && step_out) pulse_cnt <= pulse_cnt + 1'b1;
    end

    assert_step_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(step_out) |-> $past(tick));

    assert_exact_count_R3: assert property (@(posedge clk) disable iff (rst)
        load |-> (pulse_cnt == {1'b0, act_cnt}));

    assert_step_in_window_R9: assert property (@(posedge clk) disable iff (rst)
        step_out |-> ((pos != '0) && (pos <= act_win)));

    assert_ready_closed_last_R6: assert property (@(posedge clk) disable iff (rst)
        (pos == POS_LAST) |-> !cfg_ready);

    assert_ready_rise_on_tick_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_ready) |-> $past(tick));
endmodule

bind step_burst_gen sbg_checker #(
    .CNT_W(CNT_W), .WIN_W(WIN_W), .FRAME_TICKS(FRAME_TICKS)
) u_sbg_checker (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .load      (load),
    .pos       (pos),
    .act_cnt   (act_cnt),
    .act_win   (act_win),
    .cfg_ready (cfg_ready),
    .step_out  (step_out)
);

// File: tb/step_burst_gen_bench.sv
module step_burst_gen_bench;
    localparam int TD    = 2;
    localparam int F     = 400;
    localparam int DW    = 300;
    localparam int CNT_W = 8;
    localparam int ACC_W = 16;
    localparam int WIN_W = $clog2(F);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_valid = 1'b0;
    logic [CNT_W-1:0] cfg_count = '0;
    logic [WIN_W-1:0] cfg_window = '0;
    logic             cfg_ready;
    logic             step_out;

    int checks = 0;
    int errors = 0;
    string cur_tag = "R1";

    step_burst_gen #(
        .TICK_DIV(TD), .FRAME_TICKS(F), .DEF_WIN(DW),
        .CNT_W(CNT_W), .ACC_W(ACC_W), .WIN_W(WIN_W)
    ) u_step_burst_gen (
        .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_count(cfg_count),
        .cfg_window(cfg_window), .cfg_ready(cfg_ready), .step_out(step_out)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int clampw(input int w);
        if (w < (2 ** CNT_W) - 1) return (2 ** CNT_W) - 1;
        if (w > F - 2) return F - 2;
        return w;
    endfunction

    // Behavioural reference model
    int     m_div, m_pos, m_sent, m_n, m_w, p_n, p_w, m_frames = 0;
    longint m_acc, m_inc;
    bit     m_req, m_step, p_fresh, tk, acc_now, carry;
    string  p_tag, m_tag;
    int     f_pulses, f_last;

    always @(posedge clk) begin
        if (rst) begin
            m_div = 0; m_pos = 0; m_acc = 0; m_inc = 0; m_sent = 0;
            m_n = 0; m_w = clampw(DW); p_n = 0; p_w = m_w;
            m_req = 1; m_step = 0; p_fresh = 1; p_tag = "R1"; m_tag = "R1";
            f_pulses = 0; f_last = 0;
        end else begin
            acc_now = cfg_valid && m_req;
            tk = (m_div == TD - 1);
            m_div = tk ? 0 : m_div + 1;
            if (tk) begin
                if (step_out) begin f_pulses++; f_last = m_pos; end
                if (m_pos < m_w) begin
                    m_acc = m_acc + m_inc;
                    carry = (m_acc >= (64'd1 << ACC_W));
                    m_acc = m_acc % (64'd1 << ACC_W);
                    m_step = carry && (m_sent < m_n);
                    if (m_step) m_sent++;
                end else begin
                    m_step = 0;
                end
                if (m_pos == m_w - 1) m_req = 1;
                if (m_pos == F - 2) m_req = 0;
                if (m_pos == F - 1) begin
                    chk(f_pulses == m_n, m_tag, f_pulses, m_n);
                    if (m_n > 0) chk(f_last <= m_w, "R5 last pulse inside window", f_last, m_w);
                    m_n = p_n; m_w = p_w;
                    m_inc = ((longint'(p_n) << ACC_W) + p_w - 1) / p_w;
                    m_acc = 0; m_sent = 0; m_pos = 0;
                    m_tag = p_fresh ? p_tag : "R8";
                    p_fresh = 0; f_pulses = 0; f_last = 0;
                    m_frames++;
                end else begin
                    m_pos++;
                end
            end
            if (acc_now) begin
                p_n = cfg_count; p_w = clampw(cfg_window);
                p_tag = cur_tag; p_fresh = 1; m_req = 0;
            end
        end
    end

    // Per-clock comparison away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(step_out == m_step, "R4 step_out", step_out, m_step);
            chk(cfg_ready == m_req, "R6 cfg_ready", cfg_ready, m_req);
        end
    end

    task automatic send(input int n, input int w, input string tag);
        @(negedge clk);
        while (!cfg_ready) @(negedge clk);
        cur_tag = tag;
        cfg_valid = 1'b1; cfg_count = CNT_W'(n); cfg_window = WIN_W'(w);
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    task automatic wait_frame();
        int f = m_frames;
        while (m_frames == f) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        chk(step_out == 1'b0, "R1 reset step_out", step_out, 0);
        chk(cfg_ready == 1'b1, "R1 reset cfg_ready", cfg_ready, 1);

        send(1, 300, "R3 single pulse");
        send(3, 300, "R2 frame boundary apply");
        send(255, 255, "R4 full burst");
        send(0, 300, "R3 zero count");
        send(100, 300, "R4 spread 100");
        send(37, 500, "R5 clamp high");
        send(200, 10, "R5 clamp low");
        send(50, 300, "R7 ignore while not ready");
        // valid while ready is low must not be taken
        cfg_valid = 1'b1; cfg_count = 8'd3; cfg_window = WIN_W'(260);
        repeat (8) @(negedge clk);
        cfg_valid = 1'b0;
        repeat (4) wait_frame();
        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule